// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches a bank of general-purpose input pins and turns chosen pin conditions into a single interrupt request. Each pin may be armed for any mix of four conditions: a rising edge, a falling edge, a high level and a low level. The armed conditions of a pin are ORed into one event for that pin. Pins arrive asynchronously. They pass through a synchronizer, and edges are found by comparing the synchronized value with its copy from the previous cycle.

An event is captured into a sticky pending register only when the pin's interrupt enable is set. Software never writes the enable vector directly. It writes ones to an enable-set address or to an enable-clear address, and both addresses read back the current enable vector. Pending bits are cleared by writing ones to the pending address. Every bit is held on its own until it is cleared, so software can service pending pins one at a time, from pin 0 upward. The interrupt output is a registered OR of the pending bits that are also enabled.

Top module: `gpio_evt_unit`

## Requirements
- R1: With the rise-detect bit of a pin set (register address 0), a low-to-high transition of that pin sets its pending bit exactly 3 clock edges after the input changes. The first two edges fill the synchronizer, and the third latches the bit.
- R2: With the fall-detect bit of a pin set (address 1), a high-to-low transition of that pin sets its pending bit 3 edges after the input changes. A pin that only has fall detection armed ignores rising edges.
- R3: With the high-detect bit of a pin set (address 2), the pending bit is set again on every cycle while the synchronized pin is high. A clear write therefore has no lasting effect until the level goes away or detection is disarmed.
- R4: With the low-detect bit of a pin set (address 3), the pending bit is set on every cycle while the synchronized pin is low.
- R5: The detect conditions of one pin are ORed. A pin armed for both edges gets a pending bit on each of its transitions.
- R6: Writing the enable-set address (4) ORs the written ones into the enable vector. Zero bits leave their enables unchanged.
- R7: Writing the enable-clear address (5) clears the enables whose written bits are one. Zero bits leave their enables unchanged. After all ones are written to address 5 and to the pending address, and zeros to the four detect addresses, no pin activity raises a pending bit or the interrupt.
- R8: Writing ones to the pending address (6) clears those pending bits, and zero bits have no effect. A pending bit that is neither cleared nor set keeps its value, independently of every other bit.
- R9: When an event and a clear write reach the same pending bit in the same cycle, the bit stays set.
- R10: An event on a pin whose enable is zero is not latched. Enabling the pin afterwards does not recover an edge that has already passed.
- R11: The interrupt output is a register holding the OR of (pending AND enable) from the previous cycle. Clearing an enable drops the interrupt one cycle later while the pending bit stays latched.
- R12: Reads are combinational from the address. Addresses 0 to 3 return the detect registers, 4 and 5 both return the enable vector, 6 returns the pending bits, and 7 returns zero.
- R13: Reset clears the synchronizer, all detect registers, the enable vector, the pending bits and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| addr_i | input | 3 | Register address for read and write |
| wr_i | input | 1 | Write strobe, applied at the clock edge |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data for addr_i |
| irq_o | output | 1 | Aggregated registered interrupt |

## Verification
Directed cases each arm a single condition on a single pin. Each case checks that a pending bit appears on exactly the predicted edge and not before, which tells the synchronizer latency apart from an off-by-one capture. Level cases are paired with clear writes, which separates a sticky level from a set-wins collision. The edge cases are paired with late enabling, which shows that disabled events are dropped rather than stored. A long random phase uses a fixed seed and a reference model. In that phase, sparse pin toggles are mixed with random detect, enable and clear writes, so that several pending bits overlap and are cleared in arbitrary subsets. This exposes any coupling between bits or between the enable-set and enable-clear paths.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RG_RISE    = 3'd0,
      RG_FALL    = 3'd1,
      RG_HIGH    = 3'd2,
      RG_LOW     = 3'd3,
      RG_IEN_SET = 3'd4,
      RG_IEN_CLR = 3'd5,
      RG_PEND    = 3'd6,
      RG_NONE    = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic rise;
      logic fall;
      logic high;
      logic low;
   } det_cfg_t;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_evt_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_evt_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg_q;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) begin
            stg_q[i] <= stg_q[i-1];
         end
         prev_q <= stg_q[LAST];
      end
   end

   assign cur_o  = stg_q[LAST];
   assign prev_o = prev_q;

   // R1
   prev_follows_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> prev_o == $past(cur_o));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] prev_i,
   input  logic [W-1:0] rise_en_i,
   input  logic [W-1:0] fall_en_i,
   input  logic [W-1:0] high_en_i,
   input  logic [W-1:0] low_en_i,
   output logic [W-1:0] ev_o
);
   import gpio_evt_pkg::*;

   for (genvar p = 0; p < W; p++) begin : g_pin
      det_cfg_t hit;
      always_comb begin
         hit.rise = rise_en_i[p] &  cur_i[p] & ~prev_i[p];
         hit.fall = fall_en_i[p] & ~cur_i[p] &  prev_i[p];
         hit.high = high_en_i[p] &  cur_i[p];
         hit.low  = low_en_i[p]  & ~cur_i[p];
      end
      assign ev_o[p] = |hit;
   end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] ev_i,
   input  logic [W-1:0] ien_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o,
   output logic         irq_o
);
   logic [W-1:0] pend_q;
   logic [W-1:0] set_v;
   logic         irq_q;

   assign set_v = ev_i & ien_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~clr_i) | set_v;
         irq_q  <= |(pend_q & ien_i);
      end
   end

   assign pend_o = pend_q;
   assign irq_o  = irq_q;

   // R8
   pend_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (pend_q & $past(clr_i & ~(ev_i & ien_i))) == '0);

   // R9
   set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (pend_q & $past(ev_i & ien_i)) == $past(ev_i & ien_i));

   // R8
   pend_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i));

   // R10
   no_disabled_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (pend_q & ~$past(pend_q) & ~$past(ien_i)) == '0);
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                               clk_i,
   input  logic                               rst_i,
   input  logic [NPINS-1:0]                   pin_i,
   input  logic [gpio_evt_pkg::REG_AW-1:0]    addr_i,
   input  logic                               wr_i,
   input  logic [NPINS-1:0]                   wdata_i,
   output logic [NPINS-1:0]                   rdata_o,
   output logic                               irq_o
);
   import gpio_evt_pkg::*;

   if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
      $error("gpio_evt_unit: NPINS must be within 1..64");
   end

   logic [NPINS-1:0] rise_q, fall_q, high_q, low_q, ien_q;
   logic [NPINS-1:0] cur_s, prev_s, ev_s, pend_s, clr_s;
   reg_sel_e         sel;

   assign sel = reg_sel_e'(addr_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rise_q <= '0;
         fall_q <= '0;
         high_q <= '0;
         low_q  <= '0;
         ien_q  <= '0;
      end else if (wr_i) begin
         case (sel)
            RG_RISE:    rise_q <= wdata_i;
            RG_FALL:    fall_q <= wdata_i;
            RG_HIGH:    high_q <= wdata_i;
            RG_LOW:     low_q  <= wdata_i;
            RG_IEN_SET: ien_q  <= ien_q | wdata_i;
            RG_IEN_CLR: ien_q  <= ien_q & ~wdata_i;
            default: ;
         endcase
      end
   end

   assign clr_s = (wr_i && sel == RG_PEND) ? wdata_i : '0;

   always_comb begin
      case (sel)
         RG_RISE:    rdata_o = rise_q;
         RG_FALL:    rdata_o = fall_q;
         RG_HIGH:    rdata_o = high_q;
         RG_LOW:     rdata_o = low_q;
         RG_IEN_SET,
         RG_IEN_CLR: rdata_o = ien_q;
         RG_PEND:    rdata_o = pend_s;
         default:    rdata_o = '0;
      endcase
   end

   gpio_evt_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (pin_i),
      .cur_o (cur_s),
      .prev_o(prev_s)
   );

   gpio_evt_detect #(.W(NPINS)) u_detect (
      .cur_i    (cur_s),
      .prev_i   (prev_s),
      .rise_en_i(rise_q),
      .fall_en_i(fall_q),
      .high_en_i(high_q),
      .low_en_i (low_q),
      .ev_o     (ev_s)
   );

   gpio_evt_status #(.W(NPINS)) u_status (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .ev_i  (ev_s),
      .ien_i (ien_q),
      .clr_i (clr_s),
      .pend_o(pend_s),
      .irq_o (irq_o)
   );

   // R6
   ien_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_i && sel == RG_IEN_SET) |=> (ien_q & $past(wdata_i | ien_q)) == $past(wdata_i | ien_q));

   // R7
   ien_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_i && sel == RG_IEN_CLR) |=> (ien_q & $past(wdata_i)) == '0);

   // R11
   irq_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pend_s & ien_q) == '0 |=> !irq_o);
endmodule

// File: tb/gpio_evt_unit_tb.sv
module gpio_evt_unit_tb;
   import gpio_evt_pkg::*;

   localparam int unsigned N = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] pins = '0;
   logic [2:0]   addr = 3'd7;
   logic         wr = 1'b0;
   logic [N-1:0] wd = '0;
   logic [N-1:0] rdata;
   logic         irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gpio_evt_unit #(.NPINS(N), .SYNC_STAGES(2)) u_dut (
      .clk_i  (clk),
      .rst_i  (rst),
      .pin_i  (pins),
      .addr_i (addr),
      .wr_i   (wr),
      .wdata_i(wd),
      .rdata_o(rdata),
      .irq_o  (irq)
   );

   // reference model built from the requirements
   logic [N-1:0] m_s1, m_s2, m_prev, m_rise, m_fall, m_high, m_low, m_ien, m_pend;
   logic         m_irq;

   always @(posedge clk) begin
      logic [N-1:0] ev, clr;
      ev  = (m_rise & m_s2 & ~m_prev) | (m_fall & ~m_s2 & m_prev) |
            (m_high & m_s2) | (m_low & ~m_s2);
      clr = (wr && addr == 3'd6) ? wd : '0;
      if (rst) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
         m_rise <= '0; m_fall <= '0; m_high <= '0; m_low <= '0;
         m_ien <= '0; m_pend <= '0; m_irq <= 1'b0;
      end else begin
         m_s1   <= pins;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         m_pend <= (m_pend & ~clr) | (ev & m_ien);
         m_irq  <= |(m_pend & m_ien);
         if (wr) begin
            case (addr)
               3'd0: m_rise <= wd;
               3'd1: m_fall <= wd;
               3'd2: m_high <= wd;
               3'd3: m_low  <= wd;
               3'd4: m_ien  <= m_ien | wd;
               3'd5: m_ien  <= m_ien & ~wd;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [N-1:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_rise;
         3'd1: return m_fall;
         3'd2: return m_high;
         3'd3: return m_low;
         3'd4, 3'd5: return m_ien;
         3'd6: return m_pend;
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // R11 interrupt output tracked every cycle against the model
   always @(negedge clk) begin
      if (!rst) chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wreg(input logic [2:0] a, input logic [N-1:0] d);
      addr = a; wd = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; wd = '0;
   endtask

   task automatic rchk(input string tag, input logic [2:0] a, input logic [N-1:0] exp);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      cyc(3);
      rst = 1'b0;
      @(negedge clk);
      // R13 reset state
      for (int a = 0; a < 8; a++) rchk("R13 reset read", 3'(a), '0);
      chk("R13 irq", {31'd0, irq}, '0);

      // R6 / R12 enable set
      wreg(3'd4, 32'h9);
      rchk("R6 set", 3'd4, 32'h9);
      wreg(3'd4, 32'h10);
      rchk("R6 zeros keep", 3'd4, 32'h19);
      rchk("R12 clr addr reads enables", 3'd5, 32'h19);
      // R7 enable clear
      wreg(3'd5, 32'h1);
      rchk("R7 clear", 3'd4, 32'h18);

      // R1 rising edge on pin 3, latency three edges
      wreg(3'd0, 32'h8);
      pins[3] = 1'b1;
      cyc(2);
      rchk("R1 not yet", 3'd6, '0);
      cyc(1);
      rchk("R1 latched", 3'd6, 32'h8);
      chk("R11 irq lag", {31'd0, irq}, '0);
      cyc(1);
      chk("R11 irq up", {31'd0, irq}, 32'h1);
      cyc(3);
      rchk("R8 held after edge", 3'd6, 32'h8);
      wreg(3'd6, 32'h0);
      rchk("R8 zero write", 3'd6, 32'h8);
      wreg(3'd6, 32'h8);
      rchk("R8 cleared", 3'd6, '0);

      // R3 high level, clears do not stick (R9)
      wreg(3'd2, 32'h8);
      rchk("R3 not yet", 3'd6, '0);
      cyc(1);
      rchk("R3 level sets", 3'd6, 32'h8);
      wreg(3'd6, 32'h8);
      rchk("R9 set wins", 3'd6, 32'h8);
      wreg(3'd2, 32'h0);
      wreg(3'd6, 32'h8);
      rchk("R3 gone after disarm", 3'd6, '0);

      // R2 falling edge on pin 4
      wreg(3'd1, 32'h10);
      pins[4] = 1'b1;
      cyc(4);
      rchk("R2 rise ignored", 3'd6, '0);
      pins[4] = 1'b0;
      cyc(2);
      rchk("R2 not yet", 3'd6, '0);
      cyc(1);
      rchk("R2 latched", 3'd6, 32'h10);
      wreg(3'd6, 32'h10);

      // R10 disabled pin 7
      wreg(3'd0, 32'h88);
      pins[7] = 1'b1;
      cyc(4);
      rchk("R10 disabled dropped", 3'd6, '0);
      wreg(3'd4, 32'h80);
      cyc(2);
      rchk("R10 late enable", 3'd6, '0);

      // R4 low level on pin 20
      wreg(3'd3, 32'h0010_0000);
      wreg(3'd4, 32'h0010_0000);
      cyc(1);
      rchk("R4 low sets", 3'd6, 32'h0010_0000);
      cyc(1);
      chk("R4 irq", {31'd0, irq}, 32'h1);
      // R11 enable clear drops irq, pending stays
      wreg(3'd5, 32'h0010_0000);
      cyc(1);
      chk("R11 irq drop", {31'd0, irq}, '0);
      rchk("R11 pend kept", 3'd6, 32'h0010_0000);
      wreg(3'd3, 32'h0);
      wreg(3'd6, 32'h0010_0000);
      rchk("R8 clear bit20", 3'd6, '0);

      // R5 both edges on pin 5
      wreg(3'd0, 32'h20);
      wreg(3'd1, 32'h20);
      wreg(3'd4, 32'h20);
      pins[5] = 1'b1;
      cyc(3);
      rchk("R5 rise", 3'd6, 32'h20);
      wreg(3'd6, 32'h20);
      pins[5] = 1'b0;
      cyc(3);
      rchk("R5 fall", 3'd6, 32'h20);

      // R12 readback
      rchk("R12 rise", 3'd0, 32'h20);
      rchk("R12 fall", 3'd1, 32'h20);
      rchk("R12 high", 3'd2, '0);
      rchk("R12 low", 3'd3, '0);
      rchk("R12 set", 3'd4, 32'hB8);
      rchk("R12 clr", 3'd5, 32'hB8);
      rchk("R12 spare", 3'd7, '0);

      // R7 full shutdown sequence
      wreg(3'd5, '1);
      wreg(3'd6, '1);
      for (int a = 0; a < 4; a++) wreg(3'(a), '0);
      for (int i = 0; i < 40; i++) begin
         pins = $urandom;
         @(negedge clk);
      end
      rchk("R7 quiet pend", 3'd6, '0);
      rchk("R7 quiet enable", 3'd4, '0);
      chk("R7 quiet irq", {31'd0, irq}, '0);

      // random phase (R1..R12 against model)
      for (int i = 0; i < 3000; i++) begin
         int op;
         if ($urandom_range(3) == 0) pins = pins ^ ($urandom & $urandom & $urandom);
         op = $urandom_range(9);
         wr = 1'b0;
         case (op)
            0, 1: begin addr = 3'($urandom_range(3)); wd = $urandom & $urandom; wr = 1'b1; end
            2:    begin addr = 3'd4; wd = $urandom; wr = 1'b1; end
            3:    begin addr = 3'd5; wd = $urandom & $urandom; wr = 1'b1; end
            4:    begin addr = 3'd6; wd = $urandom; wr = 1'b1; end
            5, 6: addr = 3'd6;
            default: addr = 3'($urandom_range(7));
         endcase
         @(negedge clk);
         chk("R8 random read", rdata, m_read(addr));
      end
      wr = 1'b0;
      cyc(2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule